// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Interrupt Conditions

This block controls a bank of 32 general-purpose pins through a small register port. Software chooses the direction of each pin and the level it drives. It can read back the pin levels. For every pin it can set which input condition raises a flag: a low level, a high level, a rising edge or a falling edge. A separate per-pin bit makes a pin flag on any edge, whatever its condition code says.

Input pins pass through a two-stage synchronizer. Edges are found by comparing the synchronized level with its value one cycle earlier. A detected condition sets a sticky status bit whether or not the pin is masked. Software clears a status bit by writing 1 to it. The single interrupt line is high while any status bit is set for a pin whose mask bit is 1.

The register port has no back-pressure: every request is accepted in the cycle its valid is high. A read returns its data one cycle later, marked by a response valid, and the requester must accept that response. The pin and interrupt signals are plain levels.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every register is zero, `pad_oe` and `pad_out` are zero, `irq` is low and the first read of the direction, mask and condition registers returns zero.
- R2: Bit n of the direction register (address 1) drives `pad_oe[n]`, where 1 means output. The output-data register (address 0) drives `pad_out`, where 1 means high.
- R3: A read with `bus_valid`=1 and `bus_write`=0 raises `rsp_valid` for one cycle after the request edge, with the addressed value on `rsp_data`. The addresses are: 0 data, 1 direction, 2 low-pin conditions, 3 high-pin conditions, 4 mask, 5 status, 6 any-edge select, 7 reads zero. Reading address 0 returns the output-data bit for output pins and the synchronized pin level for input pins.
- R4: Condition code 2'b10 flags a pin on a rising edge of its synchronized level and not on a falling edge.
- R5: Condition code 2'b11 flags a pin on a falling edge and not on a rising edge.
- R6: Condition code 2'b01 flags a pin in every cycle its synchronized level is high.
- R7: Condition code 2'b00 flags a pin in every cycle its synchronized level is low.
- R8: When a pin's any-edge bit (address 6) is 1, the pin flags on both edges and its condition code is ignored.
- R9: A flagged condition sets the pin's status bit (address 5) even when its mask bit is 0. The bit then stays set until it is cleared.
- R10: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A condition detected in the same cycle as the clear keeps the bit set.
- R11: `irq` is the OR over all pins of status AND mask (address 4, where 1 enables).
- R12: A pin edge applied before clock edge k reaches the status register at edge k+2, so `irq` first rises after edge k+2.
- R13: Pin n's condition field sits at bits 2n+1:2n of address 2 for n < 16, and at bits 2(n-16)+1:2(n-16) of address 3 for n ≥ 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Register request valid, always accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after the read |
| rsp_data | output | 32 | Read response data |
| pad_in | input | 32 | Asynchronous pin levels |
| pad_out | output | 32 | Levels driven on output pins |
| pad_oe | output | 32 | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
Several properties are checked on every cycle. Status bits never drop without a clear and never rise without a detected condition. A cleared bit falls unless a condition arrived with the clear. Any flag produced in edge mode comes with a real change of the synchronized level. A response appears only after a read, and `irq` stays low while the status is empty. Only the bench scenarios can show the functional behaviour: which code produces which flag, the bit layout of the condition fields, the read-back mix of output data and pin levels, the same-cycle clear collision, and the exact two-edge latency from a pin to the interrupt.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] REG_DATA   = 3'd0;
  localparam logic [ADDR_W-1:0] REG_DIR    = 3'd1;
  localparam logic [ADDR_W-1:0] REG_CFG_LO = 3'd2;
  localparam logic [ADDR_W-1:0] REG_CFG_HI = 3'd3;
  localparam logic [ADDR_W-1:0] REG_MASK   = 3'd4;
  localparam logic [ADDR_W-1:0] REG_STATUS = 3'd5;
  localparam logic [ADDR_W-1:0] REG_BOTH   = 3'd6;

  localparam logic [1:0] COND_LOW  = 2'b00;
  localparam logic [1:0] COND_HIGH = 2'b01;
  localparam logic [1:0] COND_RISE = 2'b10;
  localparam logic [1:0] COND_FALL = 2'b11;
endpackage

// File: rtl/gpio_ctrl_sync.sv
module gpio_ctrl_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_detect.sv
module gpio_ctrl_detect
  import gpio_ctrl_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   lvl,
  input  logic [2*NPINS-1:0] cond,
  input  logic [NPINS-1:0]   both,
  output logic [NPINS-1:0]   hit
);
  logic [NPINS-1:0] prev;
  logic [NPINS-1:0] rise;
  logic [NPINS-1:0] fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [1:0] code;
    logic       h;
    assign code = cond[2*p +: 2];

    always_comb begin
      if (both[p]) begin
        h = rise[p] | fall[p];
      end else begin
        case (code)
          COND_LOW:  h = ~lvl[p];
          COND_HIGH: h = lvl[p];
          COND_RISE: h = rise[p];
          default:   h = fall[p];
        endcase
      end
    end
    assign hit[p] = h;

    // R8: an any-edge flag needs a real change of the synchronized level
    assert_both_needs_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (both[p] && hit[p]) |-> (lvl[p] != prev[p]));
    // R4 / R5: edge-coded flags need a level change too
    assert_edge_code_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!both[p] && cond[2*p+1] && hit[p]) |-> (lvl[p] != prev[p]));
  end
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_ctrl_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NPINS-1:0]   bus_wdata,
  output logic               rsp_valid,
  output logic [NPINS-1:0]   rsp_data,
  input  logic [NPINS-1:0]   lvl,
  input  logic [NPINS-1:0]   hit,
  output logic [NPINS-1:0]   dout,
  output logic [NPINS-1:0]   dir,
  output logic [2*NPINS-1:0] cond,
  output logic [NPINS-1:0]   mask,
  output logic [NPINS-1:0]   both,
  output logic [NPINS-1:0]   status
);
  logic [NPINS-1:0] dout_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, both_q, status_q;
  logic [NPINS-1:0] clr_mask, status_d, rd_mux;
  logic             wr, rd;

  assign wr = bus_valid & bus_write;
  assign rd = bus_valid & ~bus_write;
  assign clr_mask = (wr && bus_addr == REG_STATUS) ? bus_wdata : '0;
  assign status_d = (status_q & ~clr_mask) | hit;

  always_comb begin
    case (bus_addr)
      REG_DATA:   rd_mux = (dout_q & dir_q) | (lvl & ~dir_q);
      REG_DIR:    rd_mux = dir_q;
      REG_CFG_LO: rd_mux = cfg_lo_q;
      REG_CFG_HI: rd_mux = cfg_hi_q;
      REG_MASK:   rd_mux = mask_q;
      REG_STATUS: rd_mux = status_q;
      REG_BOTH:   rd_mux = both_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q    <= '0;
      dir_q     <= '0;
      cfg_lo_q  <= '0;
      cfg_hi_q  <= '0;
      mask_q    <= '0;
      both_q    <= '0;
      status_q  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (wr) begin
        case (bus_addr)
          REG_DATA:   dout_q   <= bus_wdata;
          REG_DIR:    dir_q    <= bus_wdata;
          REG_CFG_LO: cfg_lo_q <= bus_wdata;
          REG_CFG_HI: cfg_hi_q <= bus_wdata;
          REG_MASK:   mask_q   <= bus_wdata;
          REG_BOTH:   both_q   <= bus_wdata;
          default:    ;
        endcase
      end
      status_q  <= status_d;
      rsp_valid <= rd;
      if (rd) rsp_data <= rd_mux;
    end
  end

  assign dout   = dout_q;
  assign dir    = dir_q;
  assign cond   = {cfg_hi_q, cfg_lo_q};
  assign mask   = mask_q;
  assign both   = both_q;
  assign status = status_q;

  // R3: a response only follows a read request
  assert_rsp_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd));
  // R9: a status bit never drops unless a clear for it was written
  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status_q) & ~status_q & ~$past(clr_mask)) == '0));
  // R9: a status bit only rises from a detected condition
  assert_status_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(hit)) == '0));
  // R10: a clear without a colliding condition empties the bit
  assert_clear_takes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & $past(clr_mask) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NPINS     = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic              rsp_valid,
  output logic [NPINS-1:0]  rsp_data,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  logic [NPINS-1:0]   lvl, hit, mask, both, status;
  logic [2*NPINS-1:0] cond;

  gpio_ctrl_sync #(.W(NPINS), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl)
  );

  gpio_ctrl_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .cond(cond), .both(both), .hit(hit)
  );

  gpio_ctrl_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .lvl(lvl), .hit(hit),
    .dout(pad_out), .dir(pad_oe), .cond(cond), .mask(mask), .both(both),
    .status(status)
  );

  assign irq = |(status & mask);

  // R11: the interrupt is quiet while no status bit is set
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq);
  // R11: with every pin masked off the interrupt stays low
  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

// File: tb/gpio_ctrl_bench.sv
module gpio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  gpio_ctrl u_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // monitor: pop expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        vectors++; errors++;
        $display("FAIL R3: unexpected response actual %h expected none", rsp_data);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, rsp_data, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    bus_rd(3'd1, 32'h0, "R1 dir read");
    bus_rd(3'd4, 32'h0, "R1 mask read");
    bus_rd(3'd2, 32'h0, "R1 cfg read");
    // all pins low with code 00 latch, yet nothing is masked
    bus_rd(3'd5, 32'hFFFF_FFFF, "R7 R9 low-level status after reset");
    chk("R9 irq masked", {31'b0, irq}, 32'h0);

    // direction and output data
    bus_wr(3'd1, 32'h0000_FFFF);
    bus_wr(3'd0, 32'hA5A5_1234);
    chk("R2 pad_oe", pad_oe, 32'h0000_FFFF);
    chk("R2 pad_out", pad_out, 32'hA5A5_1234);
    pad_in = 32'h5A5A_00F0;
    settle();
    bus_rd(3'd0, 32'h5A5A_1234, "R3 data read mix");
    bus_wr(3'd1, 32'h0);
    bus_rd(3'd0, 32'h5A5A_00F0, "R3 data read inputs");
    bus_rd(3'd7, 32'h0, "R3 unused address");
    pad_in = 32'h0;

    // all pins rising-edge coded, then clear everything
    bus_wr(3'd2, 32'hAAAA_AAAA);
    bus_wr(3'd3, 32'hAAAA_AAAA);
    settle();
    bus_wr(3'd5, 32'hFFFF_FFFF);
    bus_rd(3'd5, 32'h0, "R10 clear all");
    bus_rd(3'd3, 32'hAAAA_AAAA, "R13 cfg hi readback");

    // R4 / R12: rising edge on pin 3 with latency
    bus_wr(3'd4, 32'h0000_0008);
    @(negedge clk);
    pad_in = 32'h0000_0008;
    @(negedge clk);
    chk("R12 irq after 1 edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R12 irq after 2 edges", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R12 R4 irq after 3 edges", {31'b0, irq}, 32'h1);
    bus_rd(3'd5, 32'h0000_0008, "R4 rising status");
    bus_wr(3'd5, 32'h0000_0008);
    bus_rd(3'd5, 32'h0, "R10 clear edge flag");
    chk("R11 irq after clear", {31'b0, irq}, 32'h0);

    // R5: falling-coded pin 17 (address 3, bits 3:2)
    bus_wr(3'd3, 32'hAAAA_AAAE);
    pad_in = 32'h0002_0008;
    settle();
    bus_rd(3'd5, 32'h0, "R5 no flag on rise");
    pad_in = 32'h0000_0008;
    settle();
    bus_rd(3'd5, 32'h0002_0000, "R5 R13 falling status");
    bus_wr(3'd5, 32'h0002_0000);

    // R6: high-level pin 20 (address 3, bits 9:8)
    bus_wr(3'd3, 32'hAAAA_A9AE);
    settle();
    bus_rd(3'd5, 32'h0, "R6 no flag while low");
    pad_in = 32'h0010_0008;
    settle();
    bus_rd(3'd5, 32'h0010_0000, "R6 high status");
    chk("R9 irq with pin unmasked", {31'b0, irq}, 32'h0);
    bus_wr(3'd5, 32'h0010_0000);
    bus_rd(3'd5, 32'h0010_0000, "R10 collision keeps bit");
    bus_wr(3'd4, 32'h0010_0008);
    chk("R11 irq on mask", {31'b0, irq}, 32'h1);
    pad_in = 32'h0000_0008;
    settle();
    bus_wr(3'd5, 32'h0010_0000);
    bus_rd(3'd5, 32'h0, "R6 clears once low");
    chk("R11 irq low", {31'b0, irq}, 32'h0);

    // R7: low-level pin 5 (address 2, bits 11:10)
    bus_wr(3'd2, 32'hAAAA_A2AA);
    settle();
    bus_rd(3'd5, 32'h0000_0020, "R7 low status");
    pad_in = 32'h0000_0028;
    settle();
    bus_wr(3'd5, 32'h0000_0020);
    bus_rd(3'd5, 32'h0, "R7 clears once high");

    // R8: any-edge on pin 8 overrides its rising code
    bus_wr(3'd6, 32'h0000_0100);
    bus_rd(3'd6, 32'h0000_0100, "R8 select readback");
    pad_in = 32'h0000_0128;
    settle();
    bus_rd(3'd5, 32'h0000_0100, "R8 rise flagged");
    bus_wr(3'd5, 32'h0000_0100);
    pad_in = 32'h0000_0020;   // pin 8 and pin 3 fall together
    settle();
    bus_rd(3'd5, 32'h0000_0100, "R8 fall flagged, R4 pin3 fall ignored");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      vectors++; errors++;
      $display("FAIL R3: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule